// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small stored-program processor built around one 16-bit accumulator. Instructions and data share a 4K-word, word-addressed memory reached through a 12-bit address. Each instruction is one 16-bit word. The top 4 bits select the operation and the low 12 bits name a memory address. The core steps through fetch, decode, an optional operand read and execute. Every memory access passes through an address register and a data buffer register. The memory is external, synchronous and single-ported, with one cycle of read latency.

The core also has an 8-bit input register that samples an input port, and an 8-bit output register with a one-cycle valid strobe. It has one interrupt request line, which is looked at only after an instruction has finished. When a request is taken, the program counter and accumulator are copied into two shadow registers. Further requests are then masked, and control moves to the handler address held in the low 12 bits of a fixed vector word. A return instruction restores both saved values and lifts the mask. A halt instruction freezes the core until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is held, the core is not halted, the output register reads 0, the output strobe is low, no write is requested and the memory address is 0. After reset the first instruction is read from address 0.
- R2: Each instruction word is fetched from the program counter, and the program counter then advances by one. Bits 15:12 are the opcode and bits 11:0 are the address. Opcode 1 loads the word at that address into the accumulator.
- R3: Opcode 3 adds the addressed word to the accumulator and opcode 4 subtracts it. Both wrap modulo 2^16, so 0x0023 + 0xFFE9 = 0x000C and 0x8000 - 0x0001 = 0x7FFF.
- R4: Opcode 2 writes the accumulator to the addressed word, with the write enable high for exactly one cycle.
- R5: Opcode 8 skips the next instruction when the condition chosen by bits 11:10 holds. 00 means the accumulator is negative, 01 means it is zero and 10 means it is positive (nonzero with bit 15 clear). 11 never skips.
- R6: Opcode 9 continues execution at the address in bits 11:0.
- R7: Opcode A sets the accumulator to zero.
- R8: Opcode 5 loads the input register, zero-extended, into the accumulator. Opcode 6 copies the low 8 bits of the accumulator to the output port and pulses the output strobe for exactly one cycle.
- R9: Opcode 7 sets the halted flag. From then until reset the flag stays set, the memory address does not change, no write happens and interrupt requests are ignored.
- R10: After an instruction completes, a pending unmasked request saves the program counter and accumulator. The core then reads the vector word at address IRQ_VEC and continues at its low 12 bits.
- R11: While a handler runs, further requests are masked. Opcode F restores the saved program counter and accumulator and unmasks requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| in_data | input | 8 | Input port, sampled into the input register |
| out_data | output | 8 | Output register |
| out_valid | output | 1 | One-cycle strobe on each output instruction |
| irq | input | 1 | Interrupt request, level |
| halted | output | 1 | Core has stopped |

## Verification
The skip instruction is driven with a negative, a zero and a positive accumulator under all four condition codes. Each of these twelve cases shows whether the right sign test was decoded, because the skipped instruction adds one to the stored result. The arithmetic tests use values that carry out of bit 15 and values that cross the sign boundary, which separates wrapping arithmetic from saturating or widened arithmetic. The interrupt test keeps the request high through the first part of the handler and has the handler clear the accumulator. Only correct masking lets the handler finish, and only a correct restore leaves the original accumulator in the main program's final result.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int IOW = 8,
  parameter logic [AW-1:0] IRQ_VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  input  logic [IOW-1:0] in_data,
  output logic [IOW-1:0] out_data,
  output logic          out_valid,
  input  logic          irq,
  output logic          halted
);
  localparam int OPW = DW - AW;

  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_DEC, S_RD1, S_RD2, S_EX,
    S_CHK, S_IV1, S_IV2, S_IV3, S_HALT
  } st_t;

  st_t st;
  logic [AW-1:0]  pc, mar, spc;
  logic [DW-1:0]  ac, ir, mbr, sac;
  logic [IOW-1:0] in_reg, out_reg;
  logic           masked;

  wire [OPW-1:0] op = ir[DW-1 -: OPW];
  wire [1:0] cond = ir[AW-1 -: 2];
  wire needs_opnd = (op == OPW'(1)) || (op == OPW'(3)) || (op == OPW'(4));
  wire ac_neg = ac[DW-1];
  wire ac_zero = (ac == '0);
  wire skip = (cond == 2'b00 && ac_neg) ||
              (cond == 2'b01 && ac_zero) ||
              (cond == 2'b10 && !ac_neg && !ac_zero);

  assign mem_addr  = mar;
  assign mem_wdata = ac;
  assign mem_we    = (st == S_EX) && (op == OPW'(2));
  assign out_data  = out_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_F0;
      pc <= '0; mar <= '0; spc <= '0;
      ac <= '0; ir <= '0; mbr <= '0; sac <= '0;
      in_reg <= '0; out_reg <= '0; out_valid <= 1'b0;
      masked <= 1'b0; halted <= 1'b0;
    end else begin
      in_reg <= in_data;
      out_valid <= 1'b0;
      case (st)
        S_F0: begin mar <= pc; st <= S_F1; end
        S_F1: st <= S_F2;
        S_F2: begin mbr <= mem_rdata; st <= S_F3; end
        S_F3: begin ir <= mbr; pc <= pc + AW'(1); st <= S_DEC; end
        S_DEC: begin
          mar <= ir[AW-1:0];
          st <= needs_opnd ? S_RD1 : S_EX;
        end
        S_RD1: st <= S_RD2;
        S_RD2: begin mbr <= mem_rdata; st <= S_EX; end
        S_EX: begin
          st <= S_CHK;
          case (op)
            OPW'(1):  ac <= mbr;
            OPW'(3):  ac <= ac + mbr;
            OPW'(4):  ac <= ac - mbr;
            OPW'(5):  ac <= DW'(in_reg);
            OPW'(6):  begin out_reg <= ac[IOW-1:0]; out_valid <= 1'b1; end
            OPW'(7):  begin halted <= 1'b1; st <= S_HALT; end
            OPW'(8):  if (skip) pc <= pc + AW'(1);
            OPW'(9):  pc <= ir[AW-1:0];
            OPW'(10): ac <= '0;
            OPW'(15): begin pc <= spc; ac <= sac; masked <= 1'b0; end
            default: ;
          endcase
        end
        S_CHK: begin
          if (irq && !masked) begin
            spc <= pc; sac <= ac; masked <= 1'b1;
            mar <= IRQ_VEC; st <= S_IV1;
          end else begin
            st <= S_F0;
          end
        end
        S_IV1: st <= S_IV2;
        S_IV2: begin mbr <= mem_rdata; st <= S_IV3; end
        S_IV3: begin pc <= mbr[AW-1:0]; st <= S_F0; end
        default: ;
      endcase
    end
  end

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F3) |=> (pc == $past(pc) + AW'(1)));
  assert_store_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_out_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(mem_addr)));
  assert_vector_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IV1) |-> (mem_addr == IRQ_VEC));
  assert_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && masked) |=> (st == S_F0));
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] VEC = 12'h0FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic mem_we;
  logic [7:0] in_data = 8'h00;
  logic [7:0] out_data;
  logic out_valid;
  logic irq = 1'b0;
  logic halted;

  int checks = 0;
  int fails = 0;
  int ov_cnt = 0;
  int wh_cnt = 0;
  logic [15:0] mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.IRQ_VEC(VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid), .irq(irq), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(negedge clk) begin
    if (out_valid) ov_cnt++;
    if (halted && mem_we) wh_cnt++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic boot();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    checks++;
    if (!halted) begin
      fails++;
      $display("FAIL %s actual=running expected=halted", req);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 halted", {15'd0, halted}, 16'd0);
    chk("R1 out_data", {8'd0, out_data}, 16'd0);
    chk("R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 mem_we", {15'd0, mem_we}, 16'd0);
    chk("R1 mem_addr", {4'd0, mem_addr}, 16'd0);
  endtask

  task automatic t_arith();
    wipe();
    mem[0] = 16'h1010; mem[1] = 16'h3011; mem[2] = 16'h2012;
    mem[3] = 16'h4013; mem[4] = 16'h2014; mem[5] = 16'h1016;
    mem[6] = 16'h4017; mem[7] = 16'h2015; mem[8] = 16'h7000;
    mem[16] = 16'h0023; mem[17] = 16'hFFE9; mem[19] = 16'h0010;
    mem[22] = 16'h8000; mem[23] = 16'h0001;
    boot();
    run_to_halt("R2 arith program");
    chk("R3 add wrap", mem[18], 16'h000C);
    chk("R3 sub below zero", mem[20], 16'hFFFC);
    chk("R3 sub sign cross", mem[21], 16'h7FFF);
    chk("R2 load untouched source", mem[16], 16'h0023);
  endtask

  task automatic t_halt();
    logic [11:0] a;
    int w0;
    a = mem_addr;
    w0 = wh_cnt;
    irq = 1'b1;
    repeat (30) @(negedge clk);
    irq = 1'b0;
    chk("R9 halted sticky", {15'd0, halted}, 16'd1);
    chk("R9 address frozen", {4'd0, mem_addr}, {4'd0, a});
    chk("R9 no writes", 16'(wh_cnt - w0), 16'd0);
  endtask

  task automatic t_skip();
    logic [15:0] vals [3];
    vals[0] = 16'hFFF0; vals[1] = 16'h0000; vals[2] = 16'h0005;
    for (int c = 0; c < 4; c++) begin
      for (int v = 0; v < 3; v++) begin
        logic taken;
        wipe();
        mem[0] = 16'h1010;
        mem[1] = 16'h8000 | 16'(c << 10);
        mem[2] = 16'h3012;
        mem[3] = 16'h2011;
        mem[4] = 16'h7000;
        mem[16] = vals[v];
        mem[18] = 16'h0001;
        taken = (c == 0 && vals[v][15]) || (c == 1 && vals[v] == 16'h0) ||
                (c == 2 && !vals[v][15] && vals[v] != 16'h0);
        boot();
        run_to_halt("R5 skip program");
        chk($sformatf("R5 skip cond=%0d val=%h", c, vals[v]), mem[17],
            taken ? vals[v] : vals[v] + 16'h1);
      end
    end
  endtask

  task automatic t_jump_clear();
    wipe();
    mem[0] = 16'h1010; mem[1] = 16'h9005; mem[2] = 16'h2011; mem[3] = 16'h7000;
    mem[5] = 16'hA000; mem[6] = 16'h2012; mem[7] = 16'h7000;
    mem[16] = 16'h1234; mem[17] = 16'hAAAA; mem[18] = 16'h5555;
    boot();
    run_to_halt("R6 jump program");
    chk("R6 jumped over store", mem[17], 16'hAAAA);
    chk("R7 clear", mem[18], 16'h0000);
  endtask

  task automatic t_io();
    int o0;
    wipe();
    in_data = 8'hA5;
    mem[0] = 16'h5000; mem[1] = 16'h2010; mem[2] = 16'h1011;
    mem[3] = 16'h6000; mem[4] = 16'h7000;
    mem[17] = 16'h1C3C;
    o0 = ov_cnt;
    boot();
    run_to_halt("R8 io program");
    repeat (2) @(negedge clk);
    chk("R8 input zero-extended", mem[16], 16'h00A5);
    chk("R8 output low byte", {8'd0, out_data}, 16'h003C);
    chk("R8 one strobe", 16'(ov_cnt - o0), 16'd1);
    in_data = 8'h00;
  endtask

  task automatic t_irq();
    wipe();
    mem[0] = 16'h1010; mem[1] = 16'h3011; mem[2] = 16'h2013; mem[3] = 16'h7000;
    mem[16] = 16'h0007; mem[17] = 16'h0001; mem[18] = 16'hBEEF;
    mem[64] = 16'hA000; mem[65] = 16'h2012; mem[66] = 16'hF000;
    mem[VEC[7:0]] = 16'h0040;
    irq = 1'b1;
    boot();
    fork
      run_to_halt("R10 interrupt program");
      begin
        while (!(mem_we && mem_addr == 12'h012)) @(negedge clk);
        irq = 1'b0;
      end
    join
    chk("R10 handler ran", mem[18], 16'h0000);
    chk("R11 acc restored and pc resumed", mem[19], 16'h0008);
    chk("R11 vector word kept", mem[VEC[7:0]], 16'h0040);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_halt();
    t_skip();
    t_jump_clear();
    t_io();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule